// File: doc/BRIEF.md
# Line-Tagged Shared Receive Queue

This block gathers received characters from four serial lines into one circular queue. Each entry keeps the 8-bit character and the 2-bit number of the line that delivered it. A consumer sees the oldest entry as one formatted 16-bit word. A single read strobe takes that entry off the queue. One line is chosen by parameter as low priority. Its characters are thrown away once the queue is more than half full, so a chatty device cannot crowd the other lines out.

Producers offer characters with a valid strobe and no ready signal. The queue never applies back-pressure, and every offered character is either stored or dropped on the same clock edge. If a store fills the ring completely, the write pointer lands on the read pointer. The block then pulses an overrun flag and the whole queue content is lost, because occupancy is counted modulo the capacity. The consumer side works the same way. The head word is always present, and a read strobe both consumes the head and counts as the acknowledgement.

A receive-done status follows the queue state while scanning is enabled. An interrupt request is raised when receive-done and the receive interrupt enable are both set. Any read drops receive-done for one cycle.

Top module: `line_rx_queue`

## Requirements
- R1: While reset is held, and after it is released with no other stimulus, `rd_word` is 0, `rx_done` is 0, `rx_irq` is 0 and `overrun` is 0.
- R2: While the queue is not empty, `rd_word` shows the oldest entry: bit 15 is 1, bits 9:8 hold the line number, bits 7:0 hold the character, and all other bits are 0.
- R3: Entries leave in arrival order. A `rd_strobe` while the queue is not empty removes the head entry at that clock edge.
- R4: While the queue is empty, `rd_word` is 0, and a `rd_strobe` changes no queue state.
- R5: A push from line `LOW_LINE` (default 3) is dropped when the occupancy before the edge is greater than DEPTH/2. The same push is stored when the occupancy is exactly DEPTH/2. Pushes from the other lines are never dropped by this rule.
- R6: `rx_done` is registered. On each edge it becomes `scan_en` AND (queue not empty), unless a read happens on that edge.
- R7: `rx_irq` is 1 exactly when `rx_done` and `rx_ie` are both 1.
- R8: Any `rd_strobe` clears `rx_done`, and so `rx_irq`, for the cycle after that edge. This holds even when the queue still holds data.
- R9: When a stored push makes the write pointer equal to the read pointer, `overrun` is 1 for the next cycle and the queue then reads as empty. With the default DEPTH of 64, this is the 64th push with no reads.
- R10: A push and a read on the same edge both take effect, and the occupancy stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Character offered this cycle |
| in_line | input | 2 | Source line of the offered character |
| in_char | input | 8 | Offered character |
| rd_strobe | input | 1 | Read of the head word; removes it when present |
| rd_word | output | 16 | Head word: valid bit 15, line 9:8, character 7:0 |
| scan_en | input | 1 | Master scan enable for receive-done |
| rx_ie | input | 1 | Receive interrupt enable |
| rx_done | output | 1 | Receive-done status |
| rx_irq | output | 1 | Interrupt request |
| overrun | output | 1 | One-cycle pulse when the ring wrapped onto unread data |

## Verification
Two situations are the hardest to reach from the ports. The first is the exact half-full boundary of the drop rule. The stimulus fills the queue with 32 characters from one line, then offers two characters from the low-priority line back to back. The first of these must be stored at occupancy 32 and the second dropped at occupancy 33. Draining the queue shows which entries were kept. The second is the overrun. It needs 64 unread pushes, and it is checked both through the pulse and through the queue reading empty afterwards.

// File: rtl/lrq_pkg.sv
package lrq_pkg;
  localparam int CHAR_W = 8;
  localparam int LINE_W = 2;
  localparam int WORD_W = 16;

  typedef struct packed {
    logic [LINE_W-1:0] line;
    logic [CHAR_W-1:0] ch;
  } rx_entry_t;

  localparam int ENTRY_W = $bits(rx_entry_t);

  // Valid at bit 15, line at 9:8, character at 7:0.
  function automatic logic [WORD_W-1:0] fmt_word(input logic v, input rx_entry_t e);
    logic [WORD_W-1:0] w;
    w = '0;
    if (v) begin
      w[WORD_W-1] = 1'b1;
      w[CHAR_W +: LINE_W] = e.line;
      w[CHAR_W-1:0] = e.ch;
    end
    return w;
  endfunction
endpackage

// File: rtl/lrq_store.sv
module lrq_store
  import lrq_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  rx_entry_t     wr_data,
  input  logic [AW-1:0] rd_addr,
  output rx_entry_t     rd_data
);
  rx_entry_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/lrq_ptrs.sv
module lrq_ptrs
  import lrq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int LOW_LINE = 3,
  localparam int AW = $clog2(DEPTH),
  localparam int HALF = DEPTH / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid,
  input  logic [LINE_W-1:0] push_line,
  input  logic              pop_req,
  output logic              wr_en,
  output logic [AW-1:0]     wr_addr,
  output logic [AW-1:0]     rd_addr,
  output logic              nonempty,
  output logic              overrun
);
  logic [AW-1:0] wr_q, rd_q, wr_d, rd_d, level;
  logic          low_drop, pop_acc;

  assign level    = wr_q - rd_q;   // modulo capacity
  assign nonempty = (level != '0);
  assign low_drop = (push_line == LINE_W'(LOW_LINE)) && ({1'b0, level} > (AW+1)'(HALF));
  assign wr_en    = push_valid && !low_drop;
  assign pop_acc  = pop_req && nonempty;
  assign wr_d     = wr_en   ? wr_q + 1'b1 : wr_q;
  assign rd_d     = pop_acc ? rd_q + 1'b1 : rd_q;
  assign wr_addr  = wr_q;
  assign rd_addr  = rd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q    <= '0;
      rd_q    <= '0;
      overrun <= 1'b0;
    end else begin
      wr_q    <= wr_d;
      rd_q    <= rd_d;
      overrun <= wr_en && (wr_d == rd_d);
    end
  end

  assert_empty_read_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!nonempty && pop_req && !push_valid) |=> (rd_q == $past(rd_q) && !nonempty));

  assert_low_line_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && push_line == LINE_W'(LOW_LINE) && level > AW'(HALF) && !pop_req)
      |=> (level == $past(level)));

  assert_overrun_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> !nonempty);

  assert_push_pop_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && pop_acc) |=> (level == $past(level)));
endmodule

// File: rtl/lrq_status.sv
module lrq_status (
  input  logic clk,
  input  logic rst_n,
  input  logic scan_en,
  input  logic rx_ie,
  input  logic nonempty,
  input  logic rd_strobe,
  output logic rx_done,
  output logic rx_irq
);
  always_ff @(posedge clk) begin
    if (!rst_n)         rx_done <= 1'b0;
    else if (rd_strobe) rx_done <= 1'b0;
    else                rx_done <= scan_en && nonempty;
  end

  assign rx_irq = rx_done && rx_ie;

  assert_read_clears_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |=> !rx_done);

  assert_done_has_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_done) |-> ($past(scan_en) && $past(nonempty)));
endmodule

// File: rtl/line_rx_queue.sv
module line_rx_queue
  import lrq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int LOW_LINE = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [LINE_W-1:0] in_line,
  input  logic [CHAR_W-1:0] in_char,
  input  logic              rd_strobe,
  output logic [WORD_W-1:0] rd_word,
  input  logic              scan_en,
  input  logic              rx_ie,
  output logic              rx_done,
  output logic              rx_irq,
  output logic              overrun
);
  localparam int AW = $clog2(DEPTH);

  logic          wr_en, nonempty;
  logic [AW-1:0] wr_addr, rd_addr;
  rx_entry_t     wr_data, head;

  assign wr_data = '{line: in_line, ch: in_char};

  lrq_ptrs #(.DEPTH(DEPTH), .LOW_LINE(LOW_LINE)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .push_valid(in_valid), .push_line(in_line),
    .pop_req(rd_strobe), .wr_en(wr_en), .wr_addr(wr_addr), .rd_addr(rd_addr),
    .nonempty(nonempty), .overrun(overrun)
  );

  lrq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(head)
  );

  lrq_status u_status (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .rx_ie(rx_ie),
    .nonempty(nonempty), .rd_strobe(rd_strobe), .rx_done(rx_done), .rx_irq(rx_irq)
  );

  assign rd_word = fmt_word(nonempty, head);

  assert_word_layout_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_word[15] |-> (rd_word[14:10] == 5'b0));

  assert_empty_word_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_word[15] |-> (rd_word == '0));
endmodule

// File: tb/tb_line_rx_queue.sv
module tb_line_rx_queue;
  logic        clk = 0, rst_n = 0;
  logic        in_valid = 0, rd_strobe = 0, scan_en = 1, rx_ie = 1;
  logic [1:0]  in_line = 0;
  logic [7:0]  in_char = 0;
  logic [15:0] rd_word;
  logic        rx_done, rx_irq, overrun;
  int errors = 0, checks = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  line_rx_queue dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_line(in_line), .in_char(in_char),
    .rd_strobe(rd_strobe), .rd_word(rd_word), .scan_en(scan_en), .rx_ie(rx_ie),
    .rx_done(rx_done), .rx_irq(rx_irq), .overrun(overrun)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [1:0] l, input logic [7:0] c, input logic r);
    in_valid = v; in_line = l; in_char = c; rd_strobe = r;
  endtask

  // {push, line, char, read, expected rd_word before the edge}
  localparam logic [27:0] VEC [11] = '{
    {1'b1, 2'd1, 8'h41, 1'b0, 16'h0000},
    {1'b1, 2'd2, 8'h42, 1'b0, 16'h8141},
    {1'b0, 2'd0, 8'h00, 1'b1, 16'h8141},
    {1'b1, 2'd3, 8'h43, 1'b1, 16'h8242},
    {1'b0, 2'd0, 8'h00, 1'b0, 16'h8343},
    {1'b0, 2'd0, 8'h00, 1'b1, 16'h8343},
    {1'b0, 2'd0, 8'h00, 1'b1, 16'h0000},
    {1'b1, 2'd0, 8'hFF, 1'b0, 16'h0000},
    {1'b0, 2'd0, 8'h00, 1'b0, 16'h80FF},
    {1'b0, 2'd0, 8'h00, 1'b1, 16'h80FF},
    {1'b0, 2'd0, 8'h00, 1'b0, 16'h0000}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset word", rd_word, 16'h0);
    chk("R1 reset done/irq/ovr", {13'b0, rx_done, rx_irq, overrun}, 16'h0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after release", {rd_word[15], rx_done, rx_irq, overrun}, 16'h0);

    // R2 R3 R4 R10: vector walk
    for (int i = 0; i < 11; i++) begin
      @(negedge clk);
      drive(VEC[i][27], VEC[i][26:25], VEC[i][24:17], VEC[i][16]);
      chk($sformatf("R2/R3/R4/R10 vector %0d", i), rd_word, VEC[i][15:0]);
    end
    @(negedge clk); drive(0, 0, 0, 0);
    chk("R4 empty after walk", rd_word, 16'h0);

    // R5: fill 32 from line 0
    for (int i = 0; i < 32; i++) begin
      drive(1, 2'd0, 8'(i), 0);
      @(negedge clk);
    end
    drive(1, 2'd3, 8'h33, 0); @(negedge clk);   // level 32: kept
    drive(1, 2'd3, 8'h34, 0); @(negedge clk);   // level 33: dropped
    drive(1, 2'd1, 8'h35, 0); @(negedge clk);   // other line: kept
    drive(0, 0, 0, 0); @(negedge clk);
    chk("R6 done set when data", {15'b0, rx_done}, 16'h1);
    chk("R7 irq with enable", {15'b0, rx_irq}, 16'h1);
    rx_ie = 0; #1;
    chk("R7 irq masked", {14'b0, rx_done, rx_irq}, 16'h2);
    rx_ie = 1;
    drive(0, 0, 0, 1); @(negedge clk); drive(0, 0, 0, 0);
    chk("R8 read clears done", {14'b0, rx_done, rx_irq}, 16'h0);
    @(negedge clk);
    chk("R6 done returns", {15'b0, rx_done}, 16'h1);
    for (int i = 1; i < 32; i++) begin
      chk("R3 drain order", rd_word, {8'h80, 8'(i)});
      drive(0, 0, 0, 1); @(negedge clk);
    end
    chk("R5 low line kept at half", rd_word, 16'h8333);
    drive(0, 0, 0, 1); @(negedge clk);
    chk("R5 low line dropped above half", rd_word, 16'h8135);
    drive(0, 0, 0, 1); @(negedge clk); drive(0, 0, 0, 0);
    chk("R4 empty after drain", rd_word, 16'h0);
    @(negedge clk);
    chk("R6 done clear when empty", {15'b0, rx_done}, 16'h0);

    // R6: scan disabled
    drive(1, 2'd2, 8'h5A, 0); @(negedge clk); drive(0, 0, 0, 0);
    scan_en = 0; @(negedge clk);
    chk("R6 no done without scan", {15'b0, rx_done}, 16'h0);
    scan_en = 1; drive(0, 0, 0, 1); @(negedge clk); drive(0, 0, 0, 0);

    // R9: overrun after 64 unread pushes
    for (int i = 0; i < 63; i++) begin
      drive(1, 2'd0, 8'(i), 0); @(negedge clk);
    end
    chk("R9 no overrun at 63", {15'b0, overrun}, 16'h0);
    chk("R9 head before wrap", rd_word, 16'h8000);
    drive(1, 2'd0, 8'h3F, 0); @(negedge clk); drive(0, 0, 0, 0);
    chk("R9 overrun pulse", {15'b0, overrun}, 16'h1);
    chk("R9 reads empty", rd_word, 16'h0);
    @(negedge clk);
    chk("R9 pulse ends", {15'b0, overrun}, 16'h0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule